// File: doc/BRIEF.md
# Trace Frame Qualification Generator

This block drives the qualify strobe that goes out with each frame on a debug trace port, so that an external logic analyzer captures only the frames worth keeping. On every cycle it receives a frame-valid strobe and a decoded frame: one NOP flag per command slot and a flag marking a sync frame. From these it decides whether the frame is a capture candidate. Frames made only of NOPs are always dropped. Sync frames can be dropped through a configuration bit.

An optional capture window narrows the selection further. Two configurable indices pick a start event and a stop event from a vector of local event pulses. The start event opens the window at once. The stop event closes it after a programmable delay. When window mode is on, only candidate frames inside the window are qualified.

The qualify output is registered. It is stretched by a hold timer that restarts on every qualified frame, so short bursts of interest merge into one continuous capture interval.

Top module: `trace_qual_gen`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `qual_out` and `window_flag` are 0, and no qualify pulse appears until a frame qualifies.
- R2: A frame is never qualified when `frm_valid` is 0 or when every bit of `frm_slot_nop` is 1 (bit value 1 means that slot holds a NOP).
- R3: A valid frame with at least one non-NOP slot and `frm_is_sync`=1 is unqualified when `cfg_sync_filter`=1 and qualified when `cfg_sync_filter`=0 (subject to R6).
- R4: When a frame qualifies in cycle t, `qual_out` is 1 in cycles t+1 through t+1+H, where H is `cfg_hold_len` (0 to 63); with H=0 it is a single-cycle pulse.
- R5: A qualified frame that arrives while the hold timer is still running reloads the timer to the full H, so `qual_out` stays high until H cycles after the output cycle of the latest qualified frame.
- R6: With `cfg_window_en`=1, a candidate frame qualifies only if it is inside the window. With `cfg_window_en`=0, the window state has no effect on qualification.
- R7: `evt_pulse[cfg_start_sel]`=1 sets `window_flag` from the next cycle. The stop event is `evt_pulse[cfg_stop_sel]`=1. No other event bit changes the flag.
- R8: In window mode, a frame in the same cycle as the start event may qualify even if the flag was clear. A frame in the same cycle as the stop event never qualifies.
- R9: A stop event in cycle t with delay D (`cfg_stop_dly`, 0 to 63) makes `window_flag` 0 from cycle t+1+D. Frames before that point still lie inside the window.
- R10: A new stop event while a delayed stop is pending restarts the delay from the new event; the earlier pending stop is discarded.
- R11: If a start event occurs in the cycle in which a delayed stop takes effect, `window_flag` remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A decoded frame is present this cycle |
| frm_slot_nop | input | SLOTS (3) | Per command slot: 1 = NOP |
| frm_is_sync | input | 1 | Frame is a sync frame |
| evt_pulse | input | EVT_COUNT (32) | Local event pulses |
| cfg_sync_filter | input | 1 | 1 = sync frames are never qualified |
| cfg_window_en | input | 1 | 1 = only frames inside the start/stop window qualify |
| cfg_hold_len | input | TIMER_W (6) | Extra cycles the qualify output is held |
| cfg_start_sel | input | SEL_W (5) | Index of the start event |
| cfg_stop_sel | input | SEL_W (5) | Index of the stop event |
| cfg_stop_dly | input | TIMER_W (6) | Cycles by which the stop event is deferred |
| qual_out | output | 1 | Registered qualify strobe |
| window_flag | output | 1 | Current state of the capture window |

## Verification
The bench targets the timing edges of both timers. A hold of zero must give exactly one high cycle, and a hold reload must extend the pulse rather than add to it or let it lapse. The delayed stop is checked at delays 0, 5 and a reload. An off-by-one counter would close the window one cycle early or late, and a design that ignored the reload would close it at the first stop's deadline. It also drives the same-cycle cases: a start-event frame that must qualify, a stop-event frame that must not, and a start that collides with the stop deadline and must keep the window open. A design with the wrong priority here would drop the window.

// File: rtl/tqg_pkg.sv
package tqg_pkg;

   localparam int DEF_EVT_COUNT = 32;
   localparam int DEF_SLOTS     = 3;
   localparam int DEF_TIMER_W   = 6;

   typedef struct packed {
      logic start_hit;
      logic stop_hit;
   } evt_hits_t;

endpackage

// File: rtl/tqg_frame_class.sv
module tqg_frame_class #(
   parameter int SLOTS = tqg_pkg::DEF_SLOTS
) (
   input  logic             frm_valid,
   input  logic [SLOTS-1:0] frm_slot_nop,
   input  logic             frm_is_sync,
   input  logic             cfg_sync_filter,
   output logic             candidate
);

   generate
      if (SLOTS < 1) begin : g_bad_slots
         $error("tqg_frame_class: SLOTS must be at least 1");
      end
   endgenerate

   logic any_cmd;
   logic sync_drop;

   always_comb begin
      any_cmd   = ~(&frm_slot_nop);
      sync_drop = frm_is_sync & cfg_sync_filter;
      candidate = frm_valid & any_cmd & ~sync_drop;
   end

endmodule

// File: rtl/tqg_event_window.sv
module tqg_event_window
   import tqg_pkg::*;
#(
   parameter int EVT_COUNT = DEF_EVT_COUNT,
   parameter int SEL_W     = $clog2(DEF_EVT_COUNT),
   parameter int TIMER_W   = DEF_TIMER_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [EVT_COUNT-1:0] evt_pulse,
   input  logic [SEL_W-1:0]     start_sel,
   input  logic [SEL_W-1:0]     stop_sel,
   input  logic [TIMER_W-1:0]   stop_dly,
   output evt_hits_t            hits,
   output logic                 flag
);

   generate
      if (EVT_COUNT < 2) begin : g_bad_cnt
         $error("tqg_event_window: EVT_COUNT must be at least 2");
      end
      if ((1 << SEL_W) < EVT_COUNT) begin : g_bad_sel
         $error("tqg_event_window: SEL_W too narrow for EVT_COUNT");
      end
   endgenerate

   logic [EVT_COUNT-1:0] start_match;
   logic [EVT_COUNT-1:0] stop_match;

   for (genvar i = 0; i < EVT_COUNT; i++) begin : g_sel
      assign start_match[i] = evt_pulse[i] & (start_sel == SEL_W'(i));
      assign stop_match[i]  = evt_pulse[i] & (stop_sel  == SEL_W'(i));
   end

   assign hits.start_hit = |start_match;
   assign hits.stop_hit  = |stop_match;

   logic               pend;
   logic [TIMER_W-1:0] dly_cnt;
   logic               stop_fire;

   always_comb begin
      if (hits.stop_hit) stop_fire = (stop_dly == '0);
      else               stop_fire = pend && (dly_cnt == TIMER_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         dly_cnt <= '0;
      end else if (hits.stop_hit) begin
         pend    <= (stop_dly != '0);
         dly_cnt <= stop_dly;
      end else if (pend) begin
         pend    <= (dly_cnt != TIMER_W'(1));
         dly_cnt <= dly_cnt - TIMER_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flag <= 1'b0;
      else if (hits.start_hit) flag <= 1'b1;
      else if (stop_fire)      flag <= 1'b0;
   end

   AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      hits.start_hit |=> flag); // R11

   AST_STOP_NODELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (hits.stop_hit && !hits.start_hit && stop_dly == '0) |=> !flag); // R9

   AST_STOP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (hits.stop_hit && stop_dly != '0) |=> (pend && dly_cnt == $past(stop_dly))); // R10

   AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!hits.start_hit && !hits.stop_hit && !pend) |=> $stable(flag)); // R7

endmodule

// File: rtl/tqg_hold_stretch.sv
module tqg_hold_stretch #(
   parameter int TIMER_W = tqg_pkg::DEF_TIMER_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               qual_now,
   input  logic [TIMER_W-1:0] hold_len,
   output logic               qual_out
);

   generate
      if (TIMER_W < 1 || TIMER_W > 16) begin : g_bad_w
         $error("tqg_hold_stretch: TIMER_W must be 1..16");
      end
   endgenerate

   logic [TIMER_W-1:0] hold_cnt;
   logic               hold_busy;

   assign hold_busy = (hold_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hold_cnt <= '0;
      else if (qual_now)  hold_cnt <= hold_len;
      else if (hold_busy) hold_cnt <= hold_cnt - TIMER_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qual_out <= 1'b0;
      else        qual_out <= qual_now | hold_busy;
   end

   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |=> !qual_out); // R1

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!qual_now && !hold_busy) |=> !qual_out); // R2

   AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      qual_now |=> (qual_out && hold_cnt == $past(hold_len))); // R5

   AST_HOLD_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
      (!qual_now && hold_busy) |=> (qual_out && hold_cnt == $past(hold_cnt) - TIMER_W'(1))); // R4

endmodule

// File: rtl/trace_qual_gen.sv
module trace_qual_gen
   import tqg_pkg::*;
#(
   parameter int EVT_COUNT = DEF_EVT_COUNT,
   parameter int SLOTS     = DEF_SLOTS,
   parameter int TIMER_W   = DEF_TIMER_W,
   parameter int SEL_W     = $clog2(DEF_EVT_COUNT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frm_valid,
   input  logic [SLOTS-1:0]     frm_slot_nop,
   input  logic                 frm_is_sync,
   input  logic [EVT_COUNT-1:0] evt_pulse,
   input  logic                 cfg_sync_filter,
   input  logic                 cfg_window_en,
   input  logic [TIMER_W-1:0]   cfg_hold_len,
   input  logic [SEL_W-1:0]     cfg_start_sel,
   input  logic [SEL_W-1:0]     cfg_stop_sel,
   input  logic [TIMER_W-1:0]   cfg_stop_dly,
   output logic                 qual_out,
   output logic                 window_flag
);

   logic      candidate;
   evt_hits_t hits;
   logic      in_window;
   logic      qual_now;

   tqg_frame_class #(.SLOTS(SLOTS)) u_class (
      .frm_valid       (frm_valid),
      .frm_slot_nop    (frm_slot_nop),
      .frm_is_sync     (frm_is_sync),
      .cfg_sync_filter (cfg_sync_filter),
      .candidate       (candidate)
   );

   tqg_event_window #(
      .EVT_COUNT (EVT_COUNT),
      .SEL_W     (SEL_W),
      .TIMER_W   (TIMER_W)
   ) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_pulse (evt_pulse),
      .start_sel (cfg_start_sel),
      .stop_sel  (cfg_stop_sel),
      .stop_dly  (cfg_stop_dly),
      .hits      (hits),
      .flag      (window_flag)
   );

   always_comb begin
      in_window = (window_flag | hits.start_hit) & ~hits.stop_hit;
      qual_now  = candidate & (~cfg_window_en | in_window);
   end

   tqg_hold_stretch #(.TIMER_W(TIMER_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .qual_now (qual_now),
      .hold_len (cfg_hold_len),
      .qual_out (qual_out)
   );

   AST_STOP_FRAME_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_window_en && hits.stop_hit && !u_hold.hold_busy) |=> !qual_out); // R8

   AST_NOP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ((&frm_slot_nop) && !u_hold.hold_busy) |=> !qual_out); // R2

endmodule

// File: tb/trace_qual_gen_test.sv
module trace_qual_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYC    = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0;
   logic [2:0]  frm_slot_nop = 3'b111;
   logic        frm_is_sync = 1'b0;
   logic [31:0] evt_pulse = '0;
   logic        cfg_sync_filter = 1'b0;
   logic        cfg_window_en = 1'b0;
   logic [5:0]  cfg_hold_len = '0;
   logic [4:0]  cfg_start_sel = 5'd3;
   logic [4:0]  cfg_stop_sel = 5'd17;
   logic [5:0]  cfg_stop_dly = '0;
   logic        qual_out;
   logic        window_flag;

   int    checks = 0;
   int    failures = 0;
   string cur_req = "R1";
   bit    cmp_en = 1'b0;
   bit    done = 1'b0;

   trace_qual_gen uut (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_slot_nop(frm_slot_nop),
      .frm_is_sync(frm_is_sync), .evt_pulse(evt_pulse), .cfg_sync_filter(cfg_sync_filter),
      .cfg_window_en(cfg_window_en), .cfg_hold_len(cfg_hold_len), .cfg_start_sel(cfg_start_sel),
      .cfg_stop_sel(cfg_stop_sel), .cfg_stop_dly(cfg_stop_dly), .qual_out(qual_out),
      .window_flag(window_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Behavioural reference: deadlines kept as absolute cycle numbers.
   longint cyc = 0;
   longint hold_until = -1;
   longint stop_due = -1;
   bit     m_flag = 0;
   bit     m_q = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         cyc = 0; hold_until = -1; stop_due = -1; m_flag = 0; m_q = 0;
      end else begin
         bit s, p, cand, qn;
         s    = evt_pulse[cfg_start_sel];
         p    = evt_pulse[cfg_stop_sel];
         cand = frm_valid && (frm_slot_nop != 3'b111) && !(frm_is_sync && cfg_sync_filter);
         qn   = cand && (!cfg_window_en || ((m_flag || s) && !p));
         if (qn) hold_until = cyc + 1 + cfg_hold_len;
         m_q = (cyc + 1 <= hold_until);
         if (p) stop_due = cyc + cfg_stop_dly;
         if (s) m_flag = 1;
         else if (stop_due == cyc) m_flag = 0;
         if (stop_due == cyc) stop_due = -1;
         cyc++;
      end
   end

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         check(cur_req, "qual_out", qual_out, m_q);
         check(cur_req, "window_flag", window_flag, m_flag);
      end
   end

   task automatic frame(input logic v, input logic [2:0] nop, input logic sy, input logic [31:0] ev);
      frm_valid = v; frm_slot_nop = nop; frm_is_sync = sy; evt_pulse = ev;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) frame(1'b0, 3'b111, 1'b0, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "reset qual_out", qual_out, 1'b0);
      check("R1", "reset window_flag", window_flag, 1'b0);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      idle(3);

      cur_req = "R2"; cfg_hold_len = 6'd2;
      frame(1'b1, 3'b111, 1'b0, '0); frame(1'b0, 3'b010, 1'b0, '0);
      frame(1'b1, 3'b111, 1'b1, '0); idle(4);

      cur_req = "R3"; cfg_sync_filter = 1'b1;
      frame(1'b1, 3'b110, 1'b1, '0); idle(4);
      cfg_sync_filter = 1'b0;
      frame(1'b1, 3'b110, 1'b1, '0); idle(4);

      cur_req = "R4"; cfg_hold_len = 6'd5;
      frame(1'b1, 3'b011, 1'b0, '0); idle(9);
      cfg_hold_len = 6'd0;
      frame(1'b1, 3'b101, 1'b0, '0); idle(3);
      cfg_hold_len = 6'd63;
      frame(1'b1, 3'b000, 1'b0, '0); idle(68);

      cur_req = "R5"; cfg_hold_len = 6'd4;
      for (int k = 0; k < 4; k++) begin
         frame(1'b1, 3'b001, 1'b0, '0); idle(2);
      end
      idle(7);

      cur_req = "R6"; cfg_window_en = 1'b1; cfg_hold_len = 6'd0; cfg_stop_dly = 6'd0;
      frame(1'b1, 3'b000, 1'b0, '0); frame(1'b1, 3'b000, 1'b0, 32'h0000_0010); idle(2);

      cur_req = "R8";
      frame(1'b1, 3'b000, 1'b0, 32'h0000_0008);
      cur_req = "R7";
      frame(1'b1, 3'b000, 1'b0, 32'h0000_0000);
      frame(1'b1, 3'b000, 1'b0, 32'h0000_4000); frame(1'b1, 3'b000, 1'b0, '0);
      cur_req = "R8";
      frame(1'b1, 3'b000, 1'b0, 32'h0002_0000);
      frame(1'b1, 3'b000, 1'b0, '0); idle(2);

      cur_req = "R6"; cfg_window_en = 1'b0;
      frame(1'b1, 3'b000, 1'b0, '0); idle(2);
      cfg_window_en = 1'b1;

      cur_req = "R9"; cfg_stop_dly = 6'd5;
      frame(1'b0, 3'b111, 1'b0, 32'h0000_0008);
      frame(1'b1, 3'b000, 1'b0, 32'h0002_0000);
      for (int k = 0; k < 8; k++) frame(1'b1, 3'b000, 1'b0, '0);

      cur_req = "R10"; cfg_stop_dly = 6'd4;
      frame(1'b0, 3'b111, 1'b0, 32'h0000_0008);
      frame(1'b0, 3'b111, 1'b0, 32'h0002_0000); idle(2);
      frame(1'b0, 3'b111, 1'b0, 32'h0002_0000);
      for (int k = 0; k < 7; k++) frame(1'b1, 3'b000, 1'b0, '0);

      cur_req = "R11"; cfg_stop_dly = 6'd3;
      frame(1'b0, 3'b111, 1'b0, 32'h0000_0008);
      frame(1'b0, 3'b111, 1'b0, 32'h0002_0000); idle(2);
      frame(1'b0, 3'b111, 1'b0, 32'h0000_0008);
      for (int k = 0; k < 4; k++) frame(1'b1, 3'b000, 1'b0, '0);
      check("R11", "flag kept after start at stop deadline", window_flag, 1'b1);

      cur_req = "R5"; cfg_hold_len = 6'd3; cfg_stop_dly = 6'd2;
      for (int k = 0; k < 400; k++) begin
         logic [31:0] ev;
         ev = '0;
         if ($urandom_range(0, 9) == 0) ev[3] = 1'b1;
         if ($urandom_range(0, 9) == 0) ev[17] = 1'b1;
         if (k % 100 == 50) cfg_window_en = ~cfg_window_en;
         frame($urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)), $urandom_range(0, 3) == 0, ev);
      end
      idle(5);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (MAX_CYC) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule